// File: doc/BRIEF.md
# SDIO Function Access State Machine

This block is the per-function control machine of an SDIO card controller. It runs on its own, apart from the bus machine that handles host-side bus states. It follows whether the I/O function is enabled and ready. It also steps extended-read (CMD53) transfers through a waiting phase, while the function has no data yet, and a data phase, while data moves.

The surrounding controller supplies the function's enable and ready levels and a decoded CMD53 read request. The function supplies a data-available level. The controller also raises one-cycle strobes for read completion, abort, go-inactive and I/O reset. The block returns four status flags and a numeric state code:

- `st_en`: the function is enabled.
- `st_rdy`: the function is ready.
- `st_rdfl`: data is being transferred.
- `st_xfer`: a read is in progress.

A go-inactive request parks the machine in a dead state, which only a reset leaves.

Top module: `sdio_fn_access_fsm`

## Requirements
- R1: After `rst_n` is low, or in the cycle after `io_reset` is high, `state_code` is 0 (Disabled) and all four flags are 0. `io_reset` outranks every other input. State codes: 0 Disabled, 1 NotReady, 2 Idle, 3 ReadWait, 4 ReadXfer, 5 Inactive.
- R2: In Disabled the flags (en,rdy,rdfl,xfer) are 0000. With `fn_enable` high, the next state is NotReady.
- R3: In NotReady the flags are 1000. A read request is ignored there: the state stays NotReady until `fn_ready` is high, and then it becomes Idle.
- R4: In Idle the flags are 1100. A `rd_req` with `fn_ready` high moves the machine to ReadWait.
- R5: In ReadWait the flags are 1101. It holds until `data_avail` is high, and then it moves to ReadXfer with flags 1111.
- R6: In ReadXfer, `data_avail` high keeps the machine in ReadXfer. `data_avail` low between blocks returns it to ReadWait.
- R7: In ReadWait or ReadXfer, `rd_done` or `abort_req` returns the machine to Idle on the next clock. Abort takes priority over `data_avail` in the same cycle.
- R8: `go_inactive` (when `io_reset` is low) moves any state to Inactive, with flags 0000. Inactive ignores all inputs except `io_reset` and `rst_n`.
- R9: Outside Inactive, `fn_enable` low (with no `io_reset` or `go_inactive`) moves any state to Disabled on the next clock.
- R10: In Idle, `fn_ready` low moves the machine back to NotReady, even if `rd_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| io_reset | input | 1 | Synchronous I/O reset strobe |
| fn_enable | input | 1 | Function enable level |
| fn_ready | input | 1 | Function ready level |
| rd_req | input | 1 | Decoded CMD53 read request |
| data_avail | input | 1 | Function has read data available |
| rd_done | input | 1 | Read-complete strobe |
| abort_req | input | 1 | Abort strobe |
| go_inactive | input | 1 | Go-inactive request |
| st_en | output | 1 | Enabled flag |
| st_rdy | output | 1 | Ready flag |
| st_rdfl | output | 1 | Data-transfer flag |
| st_xfer | output | 1 | Read-in-progress flag |
| state_code | output | STATE_W | Current state code |

## Verification
The bench targets the following same-cycle collisions:

- **Abort with `data_avail`.** A design that let data win would enter ReadXfer instead of Idle.
- **Read request in NotReady.** A design that skipped the readiness check would start a read early.
- **`fn_ready` falling in Idle together with a request.** A design that let the request win would enter ReadWait.
- **`io_reset` with `go_inactive`.** The wrong priority would park the machine in Inactive.
- **Inputs while Inactive.** It checks that Inactive holds against enable, requests and data.
- **Gaps between blocks.** It checks that a multi-block read drops back to ReadWait when data stops.

A long run of weighted random input patterns is compared every cycle with a reference model.

// File: rtl/sdfn_pkg.sv
package sdfn_pkg;

   typedef enum logic [2:0] {
      FS_DISABLED = 3'd0,
      FS_NOTREADY = 3'd1,
      FS_IDLE     = 3'd2,
      FS_RDWAIT   = 3'd3,
      FS_RDXFER   = 3'd4,
      FS_INACTIVE = 3'd5
   } fn_state_e;

   localparam int unsigned FS_CODE_W = 3;

   typedef struct packed {
      logic en;
      logic rdy;
      logic rdfl;
      logic xfer;
   } fn_flags_t;

   function automatic fn_flags_t flags_of(fn_state_e s);
      fn_flags_t f;
      f = '0;
      case (s)
         FS_NOTREADY: f = '{en: 1'b1, rdy: 1'b0, rdfl: 1'b0, xfer: 1'b0};
         FS_IDLE:     f = '{en: 1'b1, rdy: 1'b1, rdfl: 1'b0, xfer: 1'b0};
         FS_RDWAIT:   f = '{en: 1'b1, rdy: 1'b1, rdfl: 1'b0, xfer: 1'b1};
         FS_RDXFER:   f = '{en: 1'b1, rdy: 1'b1, rdfl: 1'b1, xfer: 1'b1};
         default:     f = '0;
      endcase
      return f;
   endfunction

endpackage

// File: rtl/sdfn_next.sv
module sdfn_next
   import sdfn_pkg::*;
#(
   parameter bit HOLD_INACTIVE = 1'b1
) (
   input  fn_state_e cur,
   input  logic      io_reset,
   input  logic      fn_enable,
   input  logic      fn_ready,
   input  logic      rd_req,
   input  logic      data_avail,
   input  logic      rd_done,
   input  logic      abort_req,
   input  logic      go_inactive,
   output fn_state_e nxt
);

   fn_state_e body_nxt;
   logic      in_dead;

   generate
      if (HOLD_INACTIVE) begin : g_hold
         assign in_dead = (cur == FS_INACTIVE);
      end else begin : g_release
         assign in_dead = 1'b0;
      end
   endgenerate

   always_comb begin
      body_nxt = cur;
      case (cur)
         FS_DISABLED: body_nxt = FS_NOTREADY;
         FS_NOTREADY: if (fn_ready) body_nxt = FS_IDLE;
         FS_IDLE: begin
            if (!fn_ready)   body_nxt = FS_NOTREADY;
            else if (rd_req) body_nxt = FS_RDWAIT;
         end
         FS_RDWAIT: begin
            if (abort_req || rd_done) body_nxt = FS_IDLE;
            else if (data_avail)      body_nxt = FS_RDXFER;
         end
         FS_RDXFER: begin
            if (abort_req || rd_done) body_nxt = FS_IDLE;
            else if (!data_avail)     body_nxt = FS_RDWAIT;
         end
         default: body_nxt = FS_DISABLED;
      endcase
   end

   always_comb begin
      if (io_reset)         nxt = FS_DISABLED;
      else if (in_dead)     nxt = FS_INACTIVE;
      else if (go_inactive) nxt = FS_INACTIVE;
      else if (!fn_enable)  nxt = FS_DISABLED;
      else                  nxt = body_nxt;
   end

endmodule

// File: rtl/sdfn_flags.sv
module sdfn_flags
   import sdfn_pkg::*;
#(
   parameter bit REG_FLAGS = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  fn_state_e cur,
   input  fn_state_e nxt,
   output fn_flags_t flags
);

   generate
      if (REG_FLAGS) begin : g_reg
         fn_flags_t flags_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flags_q <= '0;
            else        flags_q <= flags_of(nxt);
         end
         assign flags = flags_q;
      end else begin : g_comb
         assign flags = flags_of(cur);
      end
   endgenerate

   assert_xfer_needs_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
      flags.xfer |-> (flags.en && flags.rdy));
   assert_rdfl_needs_xfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
      flags.rdfl |-> flags.xfer);
   assert_rdy_needs_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
      flags.rdy |-> flags.en);

endmodule

// File: rtl/sdio_fn_access_fsm.sv
module sdio_fn_access_fsm
   import sdfn_pkg::*;
#(
   parameter int unsigned STATE_W       = 3,
   parameter bit          HOLD_INACTIVE = 1'b1,
   parameter bit          REG_FLAGS     = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               io_reset,
   input  logic               fn_enable,
   input  logic               fn_ready,
   input  logic               rd_req,
   input  logic               data_avail,
   input  logic               rd_done,
   input  logic               abort_req,
   input  logic               go_inactive,
   output logic               st_en,
   output logic               st_rdy,
   output logic               st_rdfl,
   output logic               st_xfer,
   output logic [STATE_W-1:0] state_code
);

   localparam int unsigned PAD_W = STATE_W - FS_CODE_W;

   initial begin
      if (STATE_W < FS_CODE_W) $fatal(1, "STATE_W too narrow for state codes");
   end

   fn_state_e cur_q, nxt;
   fn_flags_t flags;

   sdfn_next #(.HOLD_INACTIVE(HOLD_INACTIVE)) u_next (
      .cur        (cur_q),
      .io_reset   (io_reset),
      .fn_enable  (fn_enable),
      .fn_ready   (fn_ready),
      .rd_req     (rd_req),
      .data_avail (data_avail),
      .rd_done    (rd_done),
      .abort_req  (abort_req),
      .go_inactive(go_inactive),
      .nxt        (nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_q <= FS_DISABLED;
      else        cur_q <= nxt;
   end

   sdfn_flags #(.REG_FLAGS(REG_FLAGS)) u_flags (
      .clk  (clk),
      .rst_n(rst_n),
      .cur  (cur_q),
      .nxt  (nxt),
      .flags(flags)
   );

   assign st_en   = flags.en;
   assign st_rdy  = flags.rdy;
   assign st_rdfl = flags.rdfl;
   assign st_xfer = flags.xfer;

   generate
      if (PAD_W > 0) begin : g_pad
         assign state_code = {{PAD_W{1'b0}}, cur_q};
      end else begin : g_nopad
         assign state_code = cur_q;
      end
   endgenerate

   assert_ioreset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      io_reset |=> (cur_q == FS_DISABLED && !st_en && !st_xfer));
   assert_disable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!fn_enable && !io_reset && !go_inactive && cur_q != FS_INACTIVE)
      |=> (cur_q == FS_DISABLED));
   assert_notready_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_q == FS_NOTREADY && fn_enable && !fn_ready && !io_reset && !go_inactive)
      |=> (cur_q == FS_NOTREADY));
   assert_abort_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((cur_q == FS_RDWAIT || cur_q == FS_RDXFER) && abort_req && fn_enable
       && !io_reset && !go_inactive) |=> (cur_q == FS_IDLE));
   assert_go_inactive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (go_inactive && !io_reset) |=> (cur_q == FS_INACTIVE && !st_en));
   assert_idle_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_q == FS_IDLE && fn_enable && !fn_ready && !io_reset && !go_inactive)
      |=> (cur_q == FS_NOTREADY));

   generate
      if (HOLD_INACTIVE) begin : g_chk_hold
         assert_inactive_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (cur_q == FS_INACTIVE && !io_reset) |=> (cur_q == FS_INACTIVE));
      end
   endgenerate

endmodule

// File: tb/sdio_fn_access_fsm_bench.sv
module sdio_fn_access_fsm_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic io_reset = 0, fn_enable = 0, fn_ready = 0, rd_req = 0;
   logic data_avail = 0, rd_done = 0, abort_req = 0, go_inactive = 0;
   logic st_en, st_rdy, st_rdfl, st_xfer;
   logic [2:0] state_code;

   int checks = 0;
   int errors = 0;
   int exp_s = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   sdio_fn_access_fsm u_sdio_fn_access_fsm (
      .clk(clk), .rst_n(rst_n), .io_reset(io_reset), .fn_enable(fn_enable),
      .fn_ready(fn_ready), .rd_req(rd_req), .data_avail(data_avail),
      .rd_done(rd_done), .abort_req(abort_req), .go_inactive(go_inactive),
      .st_en(st_en), .st_rdy(st_rdy), .st_rdfl(st_rdfl), .st_xfer(st_xfer),
      .state_code(state_code));

   function automatic logic [3:0] exp_flags(int s);
      case (s)
         1: return 4'b1000;
         2: return 4'b1100;
         3: return 4'b1101;
         4: return 4'b1111;
         default: return 4'b0000;
      endcase
   endfunction

   function automatic int model_next(int s);
      if (io_reset) return 0;
      if (s == 5) return 5;
      if (go_inactive) return 5;
      if (!fn_enable) return 0;
      case (s)
         0: return 1;
         1: return fn_ready ? 2 : 1;
         2: return !fn_ready ? 1 : (rd_req ? 3 : 2);
         3: return (abort_req || rd_done) ? 2 : (data_avail ? 4 : 3);
         4: return (abort_req || rd_done) ? 2 : (data_avail ? 4 : 3);
         default: return 0;
      endcase
   endfunction

   task automatic check_now(string req);
      logic [3:0] got;
      got = {st_en, st_rdy, st_rdfl, st_xfer};
      checks++;
      if (state_code !== 3'(exp_s) || got !== exp_flags(exp_s)) begin
         errors++;
         $display("FAIL %s: state=%0d flags=%b expected state=%0d flags=%b",
                  req, state_code, got, exp_s, exp_flags(exp_s));
      end
   endtask

   task automatic step(logic en, logic rdy, logic rq, logic da, logic dn,
                       logic ab, logic gi, logic ior, string req);
      fn_enable = en; fn_ready = rdy; rd_req = rq; data_avail = da;
      rd_done = dn; abort_req = ab; go_inactive = gi; io_reset = ior;
      exp_s = model_next(exp_s);
      @(negedge clk);
      check_now(req);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: run hung, actual=timeout expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'h5D10_F00D));
      repeat (3) @(negedge clk);
      exp_s = 0;
      check_now("R1 power-on reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_now("R1 after release");

      step(1,0,0,0,0,0,0,0, "R2 enable to NotReady");
      step(1,0,1,0,0,0,0,0, "R3 request rejected in NotReady");
      step(1,1,0,0,0,0,0,0, "R3 ready to Idle");
      step(1,0,1,0,0,0,0,0, "R10 ready drop beats request");
      step(1,1,0,0,0,0,0,0, "R3 back to Idle");
      step(1,1,1,0,0,0,0,0, "R4 read to ReadWait");
      step(1,1,0,0,0,0,0,0, "R5 wait holds");
      step(1,1,0,1,0,0,0,0, "R5 data to ReadXfer");
      step(1,1,0,1,0,0,0,0, "R6 continue block");
      step(1,1,0,0,0,0,0,0, "R6 gap to ReadWait");
      step(1,1,0,1,0,1,0,0, "R7 abort beats data");
      step(1,1,1,0,0,0,0,0, "R4 second read");
      step(1,1,0,1,0,0,0,0, "R5 data again");
      step(1,1,0,1,1,0,0,0, "R7 read complete");
      step(0,1,0,0,0,0,0,0, "R9 disable from Idle");
      step(1,1,0,0,0,0,0,0, "R2 re-enable");
      step(1,1,0,0,0,0,0,0, "R3 ready");
      step(1,1,1,0,0,0,0,0, "R4 read");
      step(0,1,0,1,0,0,0,0, "R9 disable from ReadWait");
      step(1,1,0,0,0,0,1,1, "R1 io_reset beats go_inactive");
      step(1,1,0,0,0,0,1,0, "R8 go inactive");
      step(1,1,1,1,0,0,0,0, "R8 inactive ignores inputs");
      step(0,0,0,0,0,1,0,0, "R8 inactive ignores disable");
      step(1,1,0,0,0,0,0,1, "R1 io_reset leaves inactive");

      for (int i = 0; i < 3000; i++) begin
         step(($urandom % 100) < 92, ($urandom % 100) < 80, ($urandom % 100) < 35,
              ($urandom % 100) < 55, ($urandom % 100) < 10, ($urandom % 100) < 8,
              ($urandom % 100) < 2, ($urandom % 100) < 3,
              "R2-model random (R4 R5 R6 R7 R8 R9)");
      end

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule